// File: doc/BRIEF.md
# Reference-Domain Clock Ratio Tracker

This block estimates how many cycles of a fast local reference clock fit into one period of a slower, unrelated input clock, such as an audio bit or frame clock. The raw input clock is brought into the reference domain through a synchroniser, and its rising edges are detected there. A counter then measures the number of whole reference cycles between consecutive edges.

Because the edges are sampled by the reference clock, each integer count carries up to one reference period of quantisation error. The count is therefore passed through a first-order IIR low-pass filter. The filter's bandwidth is chosen at run time by a shift amount. The result is an unsigned fixed-point ratio with `FRAC_W` fractional bits, together with a one-cycle strobe each time it is updated. A resampling interpolator downstream uses this ratio to place its output points.

When the input clock is derived synchronously from the reference clock, every count is the same, so the filtered ratio is exact. When the input stops, the counter saturates and a flag is raised. The filter then restarts cleanly once edges return.

Top module: `rate_ratio_tracker`

## Requirements
- R1: While reset is asserted and after it is released, before any update, `ratio` is 0, `ratioValid` is 0 and `noInput` is 0.
- R2: An accepted input edge produces a `ratioValid` pulse after the third rising `refClk` edge at which `inClk` is high (two synchroniser stages plus the filter register).
- R3: The first accepted period after reset, or after a restart caused by `noInput`, loads `ratio` with exactly count × 2^FRAC_W, regardless of `bwShift`.
- R4: Each later accepted period of count N updates `ratio` to ratio + ((N × 2^FRAC_W − ratio) arithmetically shifted right by `bwShift`), rounding toward minus infinity. The ratio never exceeds (2^CNT_W − 1) × 2^FRAC_W.
- R5: An input period of a constant N reference cycles keeps `ratio` at exactly N × 2^FRAC_W for every `bwShift`, for N from 2 upward.
- R6: The first rising input edge after reset only starts the measurement and produces no update. Exactly one update follows each further edge. An input that is already high when reset is released is not taken as an edge.
- R7: If 2^CNT_W − 1 reference cycles pass with no input edge, `noInput` goes to 1 and stays at 1 until the next edge. That edge clears the flag without producing an update, and the period that follows it is loaded as in R3.
- R8: `ratioValid` is high for exactly one cycle per update, and `ratio` changes only in cycles where `ratioValid` is high.
- R9: With `bwShift` = 0, every update sets `ratio` to the latest count with all fractional bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all logic runs on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inClk | input | 1 | Asynchronous input clock whose period is measured |
| bwShift | input | 4 | Filter shift amount; a larger value gives a lower bandwidth |
| ratio | output | CNT_W+FRAC_W | Filtered period in reference cycles, unsigned, FRAC_W fractional bits |
| ratioValid | output | 1 | One-cycle strobe marking a new `ratio` |
| noInput | output | 1 | High while the period counter is saturated |

## Verification
Every update is due on the third rising reference edge after the bench raises `inClk` on a falling edge. The bench stamps each rising input edge with the reference-cycle number and requires the matching strobe, seen at the next falling edge, to carry exactly that stamp plus three. Expected ratios come from an arithmetic model of the preload and shift-filter equations, fed with the periods the bench itself drove. A period is queued only when a later edge closes it, so the edges that open a measurement, or that follow a stall, are known to produce no strobe. A few cycles after each burst, the bench confirms that the queue is empty.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // Strobes handed from the edge/counter control to the filter datapath.
  typedef struct packed {
    logic update;   // a complete, trusted period is on the count bus
    logic preload;  // load the accumulator directly instead of filtering
  } rrtStrobe_t;

endpackage

// File: rtl/rrt_edge_counter.sv
module rrt_edge_counter
  import rrt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inClk,
  output rrtStrobe_t       strobes,
  output logic [CNT_W-1:0] periodCount,
  output logic             saturated
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam int SYNC_LEN = 3;

  // syncQ[0] and syncQ[1] form the synchroniser; syncQ[2] is the edge history.
  // Resetting to ones means a level that is already high is not an edge.
  logic [SYNC_LEN-1:0] syncQ;
  logic                riseSeen;
  logic                armed;
  logic                primed;
  logic [CNT_W-1:0]    cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_LEN-2:0], inClk};
  end

  assign riseSeen  = syncQ[SYNC_LEN-2] & ~syncQ[SYNC_LEN-1];
  assign saturated = (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      armed  <= 1'b0;
      primed <= 1'b0;
    end else if (riseSeen) begin
      cntQ  <= CNT_ONE;
      armed <= 1'b1;
      if (armed && !saturated) primed <= 1'b1;
    end else if (saturated) begin
      armed  <= 1'b0;
      primed <= 1'b0;
    end else begin
      cntQ <= cntQ + CNT_ONE;
    end
  end

  always_comb begin
    strobes.update  = riseSeen & armed & ~saturated;
    strobes.preload = ~primed;
  end

  assign periodCount = cntQ;

endmodule

// File: rtl/rrt_iir_filter.sv
module rrt_iir_filter
  import rrt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rrtStrobe_t              strobes,
  input  logic [CNT_W-1:0]        periodCount,
  input  logic [3:0]              bwShift,
  output logic [CNT_W+FRAC_W-1:0] ratio,
  output logic                    ratioValid
);

  localparam int ACC_W = CNT_W + FRAC_W;

  logic [ACC_W-1:0]      accQ;
  logic [ACC_W-1:0]      target;
  logic [ACC_W-1:0]      accNext;
  logic signed [ACC_W:0] diff;
  logic signed [ACC_W:0] step;
  logic signed [ACC_W:0] sum;
  logic                  validQ;

  assign target = {periodCount, {FRAC_W{1'b0}}};

  always_comb begin
    diff    = $signed({1'b0, target}) - $signed({1'b0, accQ});
    step    = diff >>> bwShift;
    sum     = $signed({1'b0, accQ}) + step;
    accNext = ACC_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.update;
      if (strobes.update) accQ <= strobes.preload ? target : accNext;
    end
  end

  assign ratio      = accQ;
  assign ratioValid = validQ;

endmodule

// File: rtl/rate_ratio_tracker.sv
module rate_ratio_tracker
  import rrt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 16
) (
  input  logic                    refClk,
  input  logic                    rstN,
  input  logic                    inClk,
  input  logic [3:0]              bwShift,
  output logic [CNT_W+FRAC_W-1:0] ratio,
  output logic                    ratioValid,
  output logic                    noInput
);

  rrtStrobe_t       strobes;
  logic [CNT_W-1:0] periodCount;

  rrt_edge_counter #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (refClk),
    .rstN       (rstN),
    .inClk      (inClk),
    .strobes    (strobes),
    .periodCount(periodCount),
    .saturated  (noInput)
  );

  rrt_iir_filter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_filt (
    .clk        (refClk),
    .rstN       (rstN),
    .strobes    (strobes),
    .periodCount(periodCount),
    .bwShift    (bwShift),
    .ratio      (ratio),
    .ratioValid (ratioValid)
  );

endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 16
) (
  input logic                    refClk,
  input logic                    rstN,
  input logic [3:0]              bwShift,
  input logic [CNT_W+FRAC_W-1:0] ratio,
  input logic                    ratioValid,
  input logic                    noInput
);

  localparam logic [CNT_W+FRAC_W-1:0] RATIO_CEIL = {{CNT_W{1'b1}}, {FRAC_W{1'b0}}};

  AST_VALID_SINGLE: assert property (@(posedge refClk) disable iff (!rstN)
    ratioValid |=> !ratioValid); // R8

  AST_RATIO_HELD: assert property (@(posedge refClk) disable iff (!rstN)
    !ratioValid |-> $stable(ratio)); // R8

  AST_STALL_QUIET: assert property (@(posedge refClk) disable iff (!rstN)
    noInput |-> !ratioValid); // R7

  AST_EXACT_WIDE: assert property (@(posedge refClk) disable iff (!rstN)
    (ratioValid && $past(bwShift) == 4'd0) |-> (ratio[FRAC_W-1:0] == '0)); // R9

  AST_RATIO_CEIL: assert property (@(posedge refClk) disable iff (!rstN)
    ratio <= RATIO_CEIL); // R4

endmodule

bind rate_ratio_tracker rrt_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .bwShift   (bwShift),
  .ratio     (ratio),
  .ratioValid(ratioValid),
  .noInput   (noInput)
);

// File: tb/rate_ratio_tracker_test.sv
module rate_ratio_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int FRAC_W     = 16;
  localparam int ACC_W      = CNT_W + FRAC_W;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic             refClk = 1'b0;
  logic             rstN   = 1'b0;
  logic             inClk  = 1'b0;
  logic [3:0]       bwShift = 4'd4;
  logic [ACC_W-1:0] ratio;
  logic             ratioValid;
  logic             noInput;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  int expPeriod [0:1023];
  int expRise   [0:1023];
  int wrIdx = 0;
  int rdIdx = 0;
  bit streaming = 1'b0;
  int prevP = 0;

  longint           modelAcc = 0;
  bit               modelPrimed = 1'b0;
  bit               prevValid = 1'b0;
  logic [ACC_W-1:0] prevRatio = '0;
  string            tagNow = "R4";

  rate_ratio_tracker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) uut (
    .refClk    (refClk),
    .rstN      (rstN),
    .inClk     (inClk),
    .bwShift   (bwShift),
    .ratio     (ratio),
    .ratioValid(ratioValid),
    .noInput   (noInput)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;
  always @(posedge refClk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: sampled on the falling edge, away from the active edge.
  always @(negedge refClk) begin
    if (!rstN) begin
      prevValid = 1'b0;
      prevRatio = ratio;
    end else begin
      if (ratioValid) begin
        check(!prevValid, "R8", "strobe longer than one cycle", 1, 0);
        if (rdIdx >= wrIdx) begin
          check(1'b0, "R6", "update with no closed period", rdIdx, wrIdx);
        end else begin
          int p;
          p = expPeriod[rdIdx];
          check(cyc == expRise[rdIdx] + 3, "R2", "strobe latency",
                cyc - expRise[rdIdx], 3);
          if (!modelPrimed) begin
            modelAcc    = longint'(p) <<< FRAC_W;
            modelPrimed = 1'b1;
            check(ratio == ACC_W'(modelAcc), "R3", "preload value", ratio, modelAcc);
          end else begin
            longint d;
            d = (longint'(p) <<< FRAC_W) - modelAcc;
            modelAcc = modelAcc + (d >>> bwShift);
            check(ratio == ACC_W'(modelAcc), tagNow, "filtered ratio", ratio, modelAcc);
          end
          rdIdx = rdIdx + 1;
        end
      end else begin
        check(ratio == prevRatio, "R8", "ratio moved without strobe", ratio, prevRatio);
      end
      prevValid = ratioValid;
      prevRatio = ratio;
    end
  end

  // One input period of p reference cycles, starting with a rising edge.
  task automatic driveP(input int p);
    inClk = 1'b1;
    if (streaming) begin
      expPeriod[wrIdx] = prevP;
      expRise[wrIdx]   = cyc;
      wrIdx = wrIdx + 1;
    end
    prevP = p;
    streaming = 1'b1;
    repeat (p / 2) @(negedge refClk);
    inClk = 1'b0;
    repeat (p - p / 2) @(negedge refClk);
  endtask

  task automatic doReset(input logic [3:0] k);
    rstN = 1'b0;
    inClk = 1'b0;
    streaming = 1'b0;
    bwShift = k;
    repeat (3) @(negedge refClk);
    wrIdx = 0;
    rdIdx = 0;
    modelPrimed = 1'b0;
    modelAcc = 0;
    rstN = 1'b1;
    @(negedge refClk);
  endtask

  task automatic drain();
    repeat (6) @(negedge refClk);
    check(rdIdx == wrIdx, "R6", "updates outstanding after burst", rdIdx, wrIdx);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    errors = errors + 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  initial begin
    // R1: reset state, during reset and right after release
    repeat (2) @(negedge refClk);
    check(ratio == '0, "R1", "ratio in reset", ratio, 0);
    check(ratioValid == 1'b0, "R1", "strobe in reset", ratioValid, 0);
    check(noInput == 1'b0, "R1", "stall flag in reset", noInput, 0);
    doReset(4'd4);
    repeat (2) @(negedge refClk);
    check(ratio == '0, "R1", "ratio after release", ratio, 0);
    check(ratioValid == 1'b0, "R1", "strobe after release", ratioValid, 0);
    check(noInput == 1'b0, "R1", "stall flag after release", noInput, 0);

    // R6: input high while reset is released is not an edge
    rstN = 1'b0;
    inClk = 1'b1;
    repeat (3) @(negedge refClk);
    rstN = 1'b1;
    repeat (8) @(negedge refClk);
    check(ratioValid == 1'b0 && rdIdx == 0, "R6", "level at release seen as edge", rdIdx, 0);
    inClk = 1'b0;

    // R5: constant periods, swept over lengths and shifts
    for (int k = 0; k < 16; k += 5) begin
      for (int p = 2; p <= 14; p++) begin
        doReset(4'(k));
        tagNow = "R5";
        repeat (8) driveP(p);
        drain();
      end
    end

    // R4: step and alternating periods for several bandwidths
    for (int k = 1; k < 16; k += 2) begin
      doReset(4'(k));
      tagNow = "R4";
      repeat (3) driveP(10);
      repeat (12) driveP(17);
      for (int i = 0; i < 10; i++) driveP((i % 2) ? 9 : 8);
      repeat (6) driveP(40);
      drain();
    end

    // R9: zero shift tracks the latest count exactly
    doReset(4'd0);
    tagNow = "R9";
    driveP(5); driveP(9); driveP(13); driveP(6); driveP(21); driveP(3); driveP(7);
    drain();

    // R7: stall, flag, restart with a fresh preload
    doReset(4'd3);
    tagNow = "R7";
    repeat (4) driveP(12);
    drain();
    check(noInput == 1'b0, "R7", "stall flag while streaming", noInput, 0);
    streaming = 1'b0;
    inClk = 1'b0;
    repeat (CNT_MAX + 10) @(negedge refClk);
    check(noInput == 1'b1, "R7", "stall flag after silence", noInput, 1);
    modelPrimed = 1'b0;
    driveP(20);
    check(noInput == 1'b0, "R7", "stall flag after new edge", noInput, 0);
    repeat (5) driveP(24);
    driveP(30);
    drain();

    finishRun();
  end

endmodule